// File: doc/BRIEF.md
# Reversible 5/3 Lifting Wavelet Tile Transform

This block takes one rectangular tile of unsigned samples, streamed in raster order over a valid/ready handshake, and applies between zero and five levels of the reversible integer 5/3 wavelet decomposition. Each level runs a one-dimensional lifting pass down every column of the current region, then another along every row. The four resulting quarter-size regions are the LL, HL, LH and HH subbands. The LL quarter becomes the region that the next level transforms.

Results leave through a write-only port. Each write carries a subband tag, the level number, coordinates inside the subband and a signed coefficient. Downstream storage can place each write with no further bookkeeping. The whole tile stays in an internal store between passes. The tile width and height are run-time inputs, up to the `MAX_DIM` parameter. The default `MAX_DIM` is 32, and 128 is a legal setting.

Top module: `dwt53_tile`

## Requirements
- R1: `in_ready` is high only while a tile is being loaded. Samples are accepted in raster order, row 0 first, on cycles with `in_valid && in_ready`. Width, height and level count are taken from the `cfg_*` inputs when the first sample of a tile is accepted, and later changes to `cfg_*` during that tile are ignored. In the cycle after the last sample is accepted, `in_ready` is low.
- R2: With level count 0, every sample is written back unchanged, in raster order, tagged LL with level 0.
- R3: The predict step for odd position 2n+1 of a line gives d[n] = x[2n+1] - floor((x[2n] + x[2n+2]) / 2).
- R4: The update step for even position 2n gives s[n] = x[2n] + floor((d[n-1] + d[n] + 2) / 4).
- R5: Borders mirror without repeating the edge sample: x[-1] = x[1] and x[N] = x[N-2]. A line of length 1 passes through unchanged. Odd lengths give ceil(N/2) low-pass and floor(N/2) high-pass values.
- R6: Each level filters every column first and every row second. After a pass, a line holds its low-pass values first and its high-pass values after them.
- R7: Band tag encoding: bit 0 set means horizontally high-pass and bit 1 set means vertically high-pass, so LL=0, HL=1, LH=2 and HH=3. `out_x` and `out_y` are coordinates within the tagged subband.
- R8: Within a level, writes follow raster order over the current region. Levels are emitted in ascending order, and `out_level` gives the level number starting at 1. Only the final level writes its LL subband.
- R9: The LL subband of one level, of size ceil(W/2) by ceil(H/2), is the input region of the next level.
- R10: `done` pulses for one cycle, in the cycle after the final write of a tile. `in_ready` is high in that same cycle.
- R11: `out_valid` is never high while `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | $clog2(MAX_DIM+1) | Tile width in samples, 1..MAX_DIM |
| cfg_height | input | $clog2(MAX_DIM+1) | Tile height in samples, 1..MAX_DIM |
| cfg_levels | input | $clog2(MAX_LEVELS+1) | Number of decomposition levels, 0..MAX_LEVELS |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts a sample |
| in_sample | input | IN_W | Unsigned input sample |
| out_valid | output | 1 | Coefficient write strobe |
| out_band | output | 2 | Subband tag (LL=0, HL=1, LH=2, HH=3) |
| out_level | output | $clog2(MAX_LEVELS+1) | Level of the write (0 in bypass) |
| out_x | output | $clog2(MAX_DIM) | Column within the subband |
| out_y | output | $clog2(MAX_DIM) | Row within the subband |
| out_data | output | IN_W+3+MAX_LEVELS | Signed coefficient |
| done | output | 1 | One-cycle end-of-tile pulse |

## Verification
The bench focuses on odd lengths and length-1 lines. In those cases a wrong mirror index either reads a stale line-buffer entry or misplaces the extra low-pass value, and the coefficients drift along the right or bottom edge. Tiles of 1 by N and N by 1 with several levels check that degenerate passes leave data intact rather than corrupting it. Full-scale constant and checkerboard tiles check the floor behaviour of negative sums: a design that truncates toward zero instead of flooring gives high-pass values that are off by one. Changing the configuration inputs after the first sample checks that a design which reads them live instead of latching them would stream the wrong number of coefficients. Five-level runs on shrinking regions check that level numbers, band tags and the position of the final LL write are all correct.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

   typedef enum logic [1:0] {
      BAND_LL = 2'd0,
      BAND_HL = 2'd1,
      BAND_LH = 2'd2,
      BAND_HH = 2'd3
   } band_e;

   typedef enum logic [1:0] {
      T_LOAD = 2'd0,
      T_COL  = 2'd1,
      T_ROW  = 2'd2,
      T_EMIT = 2'd3
   } tile_st_e;

   typedef enum logic [2:0] {
      L_IDLE  = 3'd0,
      L_LOAD  = 3'd1,
      L_PRED  = 3'd2,
      L_UPD   = 3'd3,
      L_STORE = 3'd4
   } lift_st_e;

   // symmetric reflection about the first and last sample
   function automatic int mirror_idx(input int i, input int n);
      if (i < 0) return -i;
      else if (i >= n) return 2 * n - 2 - i;
      else return i;
   endfunction

endpackage

// File: rtl/dwt53_tile_mem.sv
module dwt53_tile_mem #(
   parameter int DEPTH = 1024,
   parameter int DW    = 20,
   parameter int AW    = 10
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [AW-1:0]        waddr,
   input  logic signed [DW-1:0] wdata,
   input  logic [AW-1:0]        raddr,
   output logic signed [DW-1:0] rdata
);

   logic signed [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/dwt53_line_lift.sv
module dwt53_line_lift
   import dwt53_pkg::*;
#(
   parameter int MAX_DIM = 32,
   parameter int DW      = 20
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [$clog2(MAX_DIM+1)-1:0]      len,
   output logic [$clog2(MAX_DIM)-1:0]        rd_idx,
   input  logic signed [DW-1:0]              rd_data,
   output logic                              wr_en,
   output logic [$clog2(MAX_DIM)-1:0]        wr_idx,
   output logic signed [DW-1:0]              wr_data,
   output logic                              finish
);

   localparam int IW = $clog2(MAX_DIM);
   localparam int LW = $clog2(MAX_DIM + 1);

   lift_st_e             st;
   logic [LW-1:0]        cnt, len_q, half_lo, half_hi;
   logic signed [DW-1:0] lbuf [MAX_DIM];
   logic signed [DW-1:0] p_l, p_r, u_a, u_b, pred_new, upd_new, odd_v, even_v;
   logic signed [DW:0]   sp;
   logic signed [DW+1:0] su;
   logic [IW-1:0]        o_ix, e_ix;
   int                   o_i, e_i;

   assign half_lo = LW'((len_q + LW'(1)) >> 1);
   assign half_hi = LW'(len_q >> 1);

   always_comb begin
      o_i  = 2 * int'(cnt) + 1;
      e_i  = 2 * int'(cnt);
      o_ix = IW'(o_i);
      e_ix = IW'(e_i);
      odd_v  = lbuf[o_ix];
      even_v = lbuf[e_ix];
      // predict: neighbours of an odd sample
      p_l = lbuf[IW'(o_i - 1)];
      p_r = lbuf[IW'(mirror_idx(o_i + 1, int'(len_q)))];
      sp  = {p_l[DW-1], p_l} + {p_r[DW-1], p_r};
      pred_new = odd_v - DW'(sp >>> 1);
      // update: neighbouring details of an even sample
      u_a = lbuf[IW'(mirror_idx(e_i - 1, int'(len_q)))];
      u_b = lbuf[IW'(mirror_idx(e_i + 1, int'(len_q)))];
      su  = {u_a[DW-1], u_a[DW-1], u_a} + {u_b[DW-1], u_b[DW-1], u_b} + (DW+2)'(2);
      upd_new = even_v + DW'(su >>> 2);
      // deinterleaved write-back
      rd_idx  = IW'(cnt);
      wr_idx  = IW'(cnt);
      wr_en   = (st == L_STORE);
      if (cnt < half_lo) wr_data = lbuf[IW'(2 * int'(cnt))];
      else               wr_data = lbuf[IW'(2 * int'(cnt - half_lo) + 1)];
   end

   assign finish = (st == L_STORE) && (cnt == LW'(len_q - LW'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= L_IDLE;
         cnt   <= '0;
         len_q <= '0;
      end else begin
         case (st)
            L_IDLE: if (start) begin
               cnt   <= '0;
               len_q <= len;
               st    <= L_LOAD;
            end
            L_LOAD: if (cnt == LW'(len_q - LW'(1))) begin
               cnt <= '0;
               st  <= (len_q == LW'(1)) ? L_STORE : L_PRED;
            end else cnt <= cnt + LW'(1);
            L_PRED: if (cnt == LW'(half_hi - LW'(1))) begin
               cnt <= '0;
               st  <= L_UPD;
            end else cnt <= cnt + LW'(1);
            L_UPD: if (cnt == LW'(half_lo - LW'(1))) begin
               cnt <= '0;
               st  <= L_STORE;
            end else cnt <= cnt + LW'(1);
            default: if (finish) st <= L_IDLE;
                     else cnt <= cnt + LW'(1);
         endcase
      end
   end

   always_ff @(posedge clk) begin
      case (st)
         L_LOAD:  lbuf[IW'(cnt)] <= rd_data;
         L_PRED:  lbuf[o_ix] <= pred_new;
         L_UPD:   lbuf[e_ix] <= upd_new;
         default: ;
      endcase
   end

   // R5: a line never has zero length
   p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> len != '0);
   // R6: a new pass only starts when the previous line is finished
   p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> st == L_IDLE);

endmodule

// File: rtl/dwt53_tile.sv
module dwt53_tile
   import dwt53_pkg::*;
#(
   parameter int MAX_DIM    = 32,
   parameter int IN_W       = 12,
   parameter int MAX_LEVELS = 5
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [$clog2(MAX_DIM+1)-1:0]           cfg_width,
   input  logic [$clog2(MAX_DIM+1)-1:0]           cfg_height,
   input  logic [$clog2(MAX_LEVELS+1)-1:0]        cfg_levels,
   input  logic                                   in_valid,
   output logic                                   in_ready,
   input  logic [IN_W-1:0]                        in_sample,
   output logic                                   out_valid,
   output logic [1:0]                             out_band,
   output logic [$clog2(MAX_LEVELS+1)-1:0]        out_level,
   output logic [$clog2(MAX_DIM)-1:0]             out_x,
   output logic [$clog2(MAX_DIM)-1:0]             out_y,
   output logic signed [IN_W+3+MAX_LEVELS-1:0]    out_data,
   output logic                                   done
);

   localparam int CW  = $clog2(MAX_DIM + 1);
   localparam int IW  = $clog2(MAX_DIM);
   localparam int AW  = 2 * IW;
   localparam int LVW = $clog2(MAX_LEVELS + 1);
   localparam int DW  = IN_W + 3 + MAX_LEVELS;

   generate
      if (MAX_DIM < 2 || (MAX_DIM & (MAX_DIM - 1)) != 0) begin : g_bad_dim
         $error("MAX_DIM must be a power of two of at least 2");
      end
      if (MAX_LEVELS < 1 || MAX_LEVELS > 5) begin : g_bad_lvl
         $error("MAX_LEVELS must lie in 1..5");
      end
      if (IN_W < 1 || IN_W > 16) begin : g_bad_w
         $error("IN_W must lie in 1..16");
      end
   endgenerate

   tile_st_e             st;
   logic [CW-1:0]        w_q, h_q, cur_w, cur_h, eff_w, eff_h, wl, hl, lines, lf_len;
   logic [LVW-1:0]       lv_tgt, lvl, eff_lv;
   logic [IW-1:0]        ld_x, ld_y, line, ex, ey, lf_rd_idx, lf_wr_idx;
   logic                 issued, done_q, first, accept, lf_start, lf_wr_en, lf_finish;
   logic                 hi_x, hi_y, final_lvl, emit_last, ld_last;
   logic                 m_we;
   logic [AW-1:0]        m_waddr, m_raddr;
   logic signed [DW-1:0] m_wdata, m_rdata, lf_wr_data;
   band_e                band;

   assign first   = (ld_x == '0) && (ld_y == '0);
   assign eff_w   = first ? cfg_width  : w_q;
   assign eff_h   = first ? cfg_height : h_q;
   assign eff_lv  = first ? cfg_levels : lv_tgt;
   assign in_ready = (st == T_LOAD);
   assign accept  = in_valid && in_ready;
   assign ld_last = (CW'(ld_x) == CW'(eff_w - CW'(1))) && (CW'(ld_y) == CW'(eff_h - CW'(1)));

   assign wl     = CW'((cur_w + CW'(1)) >> 1);
   assign hl     = CW'((cur_h + CW'(1)) >> 1);
   assign lines  = (st == T_COL) ? cur_w : cur_h;
   assign lf_len = (st == T_ROW) ? cur_w : cur_h;
   assign lf_start = ((st == T_COL) || (st == T_ROW)) && !issued;

   dwt53_line_lift #(.MAX_DIM(MAX_DIM), .DW(DW)) u_lift (
      .clk(clk), .rst_n(rst_n), .start(lf_start), .len(lf_len),
      .rd_idx(lf_rd_idx), .rd_data(m_rdata),
      .wr_en(lf_wr_en), .wr_idx(lf_wr_idx), .wr_data(lf_wr_data),
      .finish(lf_finish)
   );

   always_comb begin
      if (st == T_LOAD) begin
         m_we    = accept;
         m_waddr = {ld_y, ld_x};
         m_wdata = {{(DW-IN_W){1'b0}}, in_sample};
      end else begin
         m_we    = lf_wr_en;
         m_waddr = (st == T_COL) ? {lf_wr_idx, line} : {line, lf_wr_idx};
         m_wdata = lf_wr_data;
      end
      if (st == T_EMIT)     m_raddr = {ey, ex};
      else if (st == T_COL) m_raddr = {lf_rd_idx, line};
      else                  m_raddr = {line, lf_rd_idx};
   end

   dwt53_tile_mem #(.DEPTH(MAX_DIM * MAX_DIM), .DW(DW), .AW(AW)) u_mem (
      .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
      .raddr(m_raddr), .rdata(m_rdata)
   );

   // emission scan over the current region
   assign hi_x      = (lvl != '0) && (CW'(ex) >= wl);
   assign hi_y      = (lvl != '0) && (CW'(ey) >= hl);
   assign band      = band_e'({hi_y, hi_x});
   assign final_lvl = (lvl == lv_tgt);
   assign emit_last = (CW'(ex) == CW'(cur_w - CW'(1))) && (CW'(ey) == CW'(cur_h - CW'(1)));

   assign out_valid = (st == T_EMIT) && ((band != BAND_LL) || final_lvl);
   assign out_band  = band;
   assign out_level = lvl;
   assign out_x     = hi_x ? IW'(CW'(ex) - wl) : ex;
   assign out_y     = hi_y ? IW'(CW'(ey) - hl) : ey;
   assign out_data  = m_rdata;
   assign done      = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= T_LOAD;
         w_q <= '0; h_q <= '0; lv_tgt <= '0; lvl <= '0;
         cur_w <= '0; cur_h <= '0;
         ld_x <= '0; ld_y <= '0; line <= '0; ex <= '0; ey <= '0;
         issued <= 1'b0; done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            T_LOAD: begin
               if (first) begin
                  w_q <= cfg_width; h_q <= cfg_height; lv_tgt <= cfg_levels;
               end
               if (accept) begin
                  if (ld_last) begin
                     ld_x <= '0; ld_y <= '0; ex <= '0; ey <= '0;
                     line <= '0; issued <= 1'b0;
                     cur_w <= eff_w; cur_h <= eff_h;
                     lvl <= (eff_lv == '0) ? '0 : LVW'(1);
                     st  <= (eff_lv == '0) ? T_EMIT : T_COL;
                  end else if (CW'(ld_x) == CW'(eff_w - CW'(1))) begin
                     ld_x <= '0; ld_y <= ld_y + IW'(1);
                  end else ld_x <= ld_x + IW'(1);
               end
            end
            T_COL, T_ROW: begin
               if (lf_start) issued <= 1'b1;
               if (lf_finish) begin
                  issued <= 1'b0;
                  if (CW'(line) == CW'(lines - CW'(1))) begin
                     line <= '0;
                     st   <= (st == T_COL) ? T_ROW : T_EMIT;
                  end else line <= line + IW'(1);
               end
            end
            default: begin
               if (emit_last) begin
                  ex <= '0; ey <= '0;
                  if (final_lvl) begin
                     done_q <= 1'b1;
                     st     <= T_LOAD;
                  end else begin
                     lvl <= lvl + LVW'(1);
                     cur_w <= wl; cur_h <= hl;
                     st <= T_COL;
                  end
               end else if (CW'(ex) == CW'(cur_w - CW'(1))) begin
                  ex <= '0; ey <= ey + IW'(1);
               end else ex <= ex + IW'(1);
            end
         endcase
      end
   end

   // R11: loading and writing never overlap
   p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid);
   // R10: done follows a write and lasts one cycle
   p_done_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid));
   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: subband coordinates stay inside the current region
   p_coord_in_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (CW'(out_x) < cur_w) && (CW'(out_y) < cur_h));
   // R8: level numbers never exceed the configured count
   p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_level <= lv_tgt);

endmodule

// File: tb/sim_dwt53_tile.sv
`timescale 1ns/1ps
module sim_dwt53_tile;

   localparam int MAX_DIM = 32;
   localparam int IN_W = 12;
   localparam int MAX_LEVELS = 5;
   localparam int CW = $clog2(MAX_DIM + 1);
   localparam int IW = $clog2(MAX_DIM);
   localparam int LVW = $clog2(MAX_LEVELS + 1);
   localparam int DW = IN_W + 3 + MAX_LEVELS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] cfg_width = '0, cfg_height = '0;
   logic [LVW-1:0] cfg_levels = '0;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] in_sample = '0;
   logic in_ready, out_valid, done;
   logic [1:0] out_band;
   logic [LVW-1:0] out_level;
   logic [IW-1:0] out_x, out_y;
   logic signed [DW-1:0] out_data;

   always #5 clk = ~clk;

   dwt53_tile #(.MAX_DIM(MAX_DIM), .IN_W(IN_W), .MAX_LEVELS(MAX_LEVELS)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
      .cfg_levels(cfg_levels), .in_valid(in_valid), .in_ready(in_ready),
      .in_sample(in_sample), .out_valid(out_valid), .out_band(out_band),
      .out_level(out_level), .out_x(out_x), .out_y(out_y), .out_data(out_data),
      .done(done)
   );

   int checks = 0, failures = 0, cycles = 0;
   int pix [MAX_DIM][MAX_DIM];
   int tm  [MAX_DIM][MAX_DIM];
   int lb  [MAX_DIM];
   int q_b[$], q_l[$], q_x[$], q_y[$], q_v[$];
   logic prev_emptied = 1'b0;
   logic tile_done = 1'b0;
   int unsigned seed = 32'h1234_5678;

   function automatic int unsigned nxt();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed >> 8;
   endfunction

   task automatic fail_msg(input string req, input string what, input int act, input int exp);
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
   endtask

   // 1-D reference: explicit d/s arrays with mirrored neighbours (R3 R4 R5)
   task automatic lift_line(input int n);
      int x[MAX_DIM];
      int d[MAX_DIM];
      int s[MAX_DIM];
      int nh, nl, xr, dl, dr;
      if (n == 1) return;
      nh = n / 2; nl = (n + 1) / 2;
      for (int k = 0; k < n; k++) x[k] = lb[k];
      for (int k = 0; k < nh; k++) begin
         xr = (2*k + 2 < n) ? x[2*k + 2] : x[n - 2];
         d[k] = x[2*k + 1] - ((x[2*k] + xr) >>> 1);
      end
      for (int k = 0; k < nl; k++) begin
         dl = (k == 0) ? d[0] : d[k - 1];
         dr = (k < nh) ? d[k] : d[nh - 1];
         s[k] = x[2*k] + ((dl + dr + 2) >>> 2);
      end
      for (int k = 0; k < nl; k++) lb[k] = s[k];
      for (int k = 0; k < nh; k++) lb[nl + k] = d[k];
   endtask

   task automatic build_model(input int w, input int h, input int lv);
      int cw, ch, hw, hh, b;
      for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) tm[y][x] = pix[y][x];
      if (lv == 0) begin
         for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) begin
            q_b.push_back(0); q_l.push_back(0); q_x.push_back(x); q_y.push_back(y);
            q_v.push_back(tm[y][x]);
         end
         return;
      end
      cw = w; ch = h;
      for (int l = 1; l <= lv; l++) begin
         for (int x = 0; x < cw; x++) begin
            for (int y = 0; y < ch; y++) lb[y] = tm[y][x];
            lift_line(ch);
            for (int y = 0; y < ch; y++) tm[y][x] = lb[y];
         end
         for (int y = 0; y < ch; y++) begin
            for (int x = 0; x < cw; x++) lb[x] = tm[y][x];
            lift_line(cw);
            for (int x = 0; x < cw; x++) tm[y][x] = lb[x];
         end
         hw = (cw + 1) / 2; hh = (ch + 1) / 2;
         for (int y = 0; y < ch; y++) for (int x = 0; x < cw; x++) begin
            b = ((y >= hh) ? 2 : 0) + ((x >= hw) ? 1 : 0);
            if (b != 0 || l == lv) begin
               q_b.push_back(b); q_l.push_back(l);
               q_x.push_back((x >= hw) ? x - hw : x);
               q_y.push_back((y >= hh) ? y - hh : y);
               q_v.push_back(tm[y][x]);
            end
         end
         cw = hw; ch = hh;
      end
   endtask

   // monitor: compares every write against the reference queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            checks++;
            if (q_v.size() == 0) fail_msg("R8", "unexpected write", 1, 0);
            else begin
               if (int'(out_band) != q_b[0]) fail_msg("R7", "band", int'(out_band), q_b[0]);
               else if (int'(out_level) != q_l[0]) fail_msg("R8", "level", int'(out_level), q_l[0]);
               else if (int'(out_x) != q_x[0]) fail_msg("R6", "x", int'(out_x), q_x[0]);
               else if (int'(out_y) != q_y[0]) fail_msg("R6", "y", int'(out_y), q_y[0]);
               else if (int'(out_data) != q_v[0]) fail_msg("R3 R4 R9", "data", int'(out_data), q_v[0]);
               void'(q_b.pop_front()); void'(q_l.pop_front()); void'(q_x.pop_front());
               void'(q_y.pop_front()); void'(q_v.pop_front());
            end
            if (in_ready) fail_msg("R11", "ready during write", 1, 0);
         end
         if (done || prev_emptied) begin
            checks++;
            if (done !== prev_emptied) fail_msg("R10", "done timing", int'(done), int'(prev_emptied));
            if (done && !in_ready) fail_msg("R10", "ready with done", 0, 1);
            if (done) tile_done = 1'b1;
         end
         prev_emptied = out_valid && (q_v.size() == 0);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_tile(input int w, input int h, input int lv, input int mode, input bit gaps);
      bit got;
      int wait_n;
      for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) begin
         case (mode)
            0: pix[y][x] = (x * 37 + y * 101) % 4096;
            1: pix[y][x] = int'(nxt() % 4096);
            2: pix[y][x] = 4095;
            default: pix[y][x] = ((x + y) % 2 == 1) ? 4095 : 0;
         endcase
      end
      build_model(w, h, lv);
      tile_done = 1'b0;
      @(negedge clk);
      cfg_width = CW'(w); cfg_height = CW'(h); cfg_levels = LVW'(lv);
      for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) begin
         got = 1'b0;
         while (!got) begin
            if (gaps && (nxt() % 3 == 0)) begin
               in_valid = 1'b0;
               @(negedge clk);
            end
            in_valid = 1'b1;
            in_sample = IN_W'(pix[y][x]);
            got = in_ready;
            @(negedge clk);
         end
         // R1: settings changed after the first sample must be ignored
         cfg_width = CW'(3); cfg_height = CW'(2); cfg_levels = LVW'(1);
      end
      in_valid = 1'b0;
      checks++;
      if (in_ready) fail_msg("R1", "ready after last sample", 1, 0);
      wait_n = 0;
      while (!tile_done && wait_n < 40000) begin
         @(negedge clk);
         wait_n++;
      end
      checks++;
      if (q_v.size() != 0) fail_msg("R8", "writes missing", q_v.size(), 0);
      q_b.delete(); q_l.delete(); q_x.delete(); q_y.delete(); q_v.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (in_ready !== 1'b1 || out_valid !== 1'b0 || done !== 1'b0)
         fail_msg("R1", "reset state", int'({in_ready, out_valid, done}), 4);
      run_tile(4, 4, 0, 1, 1'b0);    // R2 bypass
      run_tile(8, 8, 1, 0, 1'b0);    // R3 R4 R6 R7 single level
      run_tile(5, 3, 1, 1, 1'b1);    // R5 odd lengths, R1 gaps
      run_tile(1, 6, 2, 1, 1'b0);    // R5 length-1 rows
      run_tile(7, 1, 3, 0, 1'b0);    // R5 length-1 columns
      run_tile(16, 16, 5, 1, 1'b0);  // R8 R9 five levels
      run_tile(32, 32, 5, 3, 1'b0);  // full-size checkerboard, R3 floor
      run_tile(9, 11, 3, 2, 1'b1);   // constant full scale, R9
      run_tile(3, 5, 4, 1, 1'b1);    // R8 shrinking past size 1
      run_tile(1, 1, 2, 1, 1'b0);    // R5 single sample
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule